// File: doc/BRIEF.md
# Three-Phase Gate Pattern Sequencer

This block drives the six gate lines of a three-phase bridge: a high-side and a low-side line for each of the phases U, V and W. Two 6-bit pattern buffers are loaded through a simple register port. A transfer strobe copies both buffers into a two-stage pattern store. The first stage becomes the requested gate state at once. After that, the falling edge of each phase's one-shot timer pulse moves that phase's pair to the second-stage pattern. The timers that make those pulses are outside this block.

All gate lines are active-low. Each line has its own dead-time counter. When dead time is enabled, a line that is asked to go from inactive to active waits a programmable number of cycles first. A line going back to inactive does so with no wait. The pattern logic also stops both lines of a phase from being active together.

The register port is a plain control port with no back-pressure. A write is taken on every cycle in which `wr_en` is high. The read data is combinational and shows the pattern store, not the buffers.

Top module: `tpo_seq`

## Requirements
- R1: After reset, all six gate outputs are 1 (inactive), and both read selections return 0x3F.
- R2: Writing a buffer changes neither the gate outputs nor the read data until the next transfer strobe.
- R3: On a transfer strobe, the store takes both buffers. Read selection 0 then returns buffer 0 and selection 1 returns buffer 1, with bits 7:6 read as 0. With dead time disabled, the gate outputs show buffer 0 two cycles after the strobe is driven, and not before.
- R4: When `os_pulse[k]` goes from 1 to 0, the gate pair of phase k (k = 0 for U, 1 for V, 2 for W) takes its two bits from stage 1. The other pairs do not change.
- R5: Bit map in each pattern: bit 2k is the high-side line and bit 2k+1 is the low-side line of phase k. A 0 means active and a 1 means inactive. `gate_o` uses the same bit positions.
- R6: A line asked to go inactive is inactive on the next clock, whether or not dead time is enabled.
- R7: With `dt_en` = 1 and `dt_count` = N, a line asked to become active goes active N+2 cycles after the request is registered. That is N+3 cycles after the strobe is driven. With `dt_en` = 0, it goes active on the next clock.
- R8: If a line's request returns to inactive before its dead-time count ends, the line never goes active.
- R9: If a pattern asks for both lines of a pair to be active, both lines of that pair are held inactive. Two lines of one pair are never active together.
- R10: If a transfer strobe and a one-shot falling edge come in the same cycle, the transfer strobe wins.
- R11: A rising edge on `os_pulse` changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Buffer write strobe |
| wr_sel | input | 1 | Buffer select for writes (0 or 1) |
| wr_data | input | 8 | Write data; bits 5:0 are used |
| rd_sel | input | 1 | Store stage select for reads |
| rd_data | output | 8 | Selected store stage; bits 7:6 are 0 |
| xfer_trig | input | 1 | Transfer strobe |
| os_pulse | input | 3 | One-shot pulse level per phase (U, V, W) |
| dt_en | input | 1 | Dead-time enable |
| dt_count | input | 8 | Dead-time length in cycles |
| gate_o | output | 6 | Gate lines, active-low |

## Verification
A strobe or pulse edge driven in cycle c is registered at edge c+1. With dead time off, it reaches `gate_o` at edge c+2. A dead-time engage lands at edge c+N+3. The bench's driver adds the due cycle of each expected gate value to a queue. It also adds the value due one edge earlier, which catches a result that arrives too early. The monitor samples on the falling clock edge and fails any entry whose due cycle passed without a compare. Read data has no delay after a strobe, so it is checked directly after the strobe's edge.

// File: rtl/tpo_pkg.sv
package tpo_pkg;
  localparam int NUM_PHASE = 3;
  localparam int LINES     = 2 * NUM_PHASE;
  localparam int NUM_BUF   = 2;

  typedef logic [LINES-1:0] gate_vec_t;

  localparam gate_vec_t ALL_OFF = '1;

  // Forces both lines of a pair inactive when both are asked active.
  function automatic gate_vec_t pair_interlock(input gate_vec_t want);
    gate_vec_t res;
    res = want;
    for (int k = 0; k < NUM_PHASE; k++) begin
      if (!want[2*k] && !want[2*k+1]) begin
        res[2*k]   = 1'b1;
        res[2*k+1] = 1'b1;
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/tpo_buf_regs.sv
module tpo_buf_regs
  import tpo_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  logic      wr_sel,
  input  gate_vec_t wr_val,
  output gate_vec_t buf0_o,
  output gate_vec_t buf1_o
);
  gate_vec_t bank [NUM_BUF];

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank[b] <= ALL_OFF;
      end else if (wr_en && (int'(wr_sel) == b)) begin
        bank[b] <= wr_val;
      end
    end
  end

  assign buf0_o = bank[0];
  assign buf1_o = bank[1];
endmodule

// File: rtl/tpo_pattern_seq.sv
module tpo_pattern_seq
  import tpo_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 xfer_trig,
  input  logic [NUM_PHASE-1:0] os_pulse,
  input  gate_vec_t            buf0_i,
  input  gate_vec_t            buf1_i,
  output gate_vec_t            stage0_o,
  output gate_vec_t            stage1_o,
  output gate_vec_t            req_o
);
  gate_vec_t            stage0_q, stage1_q, target_q;
  logic [NUM_PHASE-1:0] os_q;
  logic [NUM_PHASE-1:0] os_fall;

  assign os_fall = os_q & ~os_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      os_q     <= '0;
      stage0_q <= ALL_OFF;
      stage1_q <= ALL_OFF;
    end else begin
      os_q <= os_pulse;
      if (xfer_trig) begin
        stage0_q <= buf0_i;
        stage1_q <= buf1_i;
      end
    end
  end

  for (genvar k = 0; k < NUM_PHASE; k++) begin : g_pair
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        target_q[2*k+1:2*k] <= 2'b11;
      end else if (xfer_trig) begin
        target_q[2*k+1:2*k] <= buf0_i[2*k+1:2*k];
      end else if (os_fall[k]) begin
        target_q[2*k+1:2*k] <= stage1_q[2*k+1:2*k];
      end
    end
  end

  assign stage0_o = stage0_q;
  assign stage1_o = stage1_q;
  assign req_o    = pair_interlock(target_q);
endmodule

// File: rtl/tpo_dt_line.sv
module tpo_dt_line #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_off,
  input  logic            dt_en,
  input  logic [DT_W-1:0] dt_count,
  output logic            gate_o
);
  logic            gate_q;
  logic            run_q;
  logic [DT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b1;
      run_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (req_off) begin
      gate_q <= 1'b1;
      run_q  <= 1'b0;
    end else if (gate_q) begin
      if (!dt_en) begin
        gate_q <= 1'b0;
        run_q  <= 1'b0;
      end else if (!run_q) begin
        cnt_q <= dt_count;
        run_q <= 1'b1;
      end else if (cnt_q == '0) begin
        gate_q <= 1'b0;
        run_q  <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else begin
      run_q <= 1'b0;
    end
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/tpo_seq.sv
module tpo_seq
  import tpo_pkg::*;
#(
  parameter int DT_W   = 8,
  parameter int REG_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 wr_sel,
  input  logic [REG_W-1:0]     wr_data,
  input  logic                 rd_sel,
  output logic [REG_W-1:0]     rd_data,
  input  logic                 xfer_trig,
  input  logic [NUM_PHASE-1:0] os_pulse,
  input  logic                 dt_en,
  input  logic [DT_W-1:0]      dt_count,
  output logic [LINES-1:0]     gate_o
);
  localparam int PAD_W = REG_W - LINES;

  gate_vec_t buf0_w, buf1_w, stage0_w, stage1_w, req_w;

  tpo_buf_regs u_bufs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .wr_val (wr_data[LINES-1:0]),
    .buf0_o (buf0_w),
    .buf1_o (buf1_w)
  );

  tpo_pattern_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer_trig (xfer_trig),
    .os_pulse  (os_pulse),
    .buf0_i    (buf0_w),
    .buf1_i    (buf1_w),
    .stage0_o  (stage0_w),
    .stage1_o  (stage1_w),
    .req_o     (req_w)
  );

  for (genvar i = 0; i < LINES; i++) begin : g_line
    tpo_dt_line #(.DT_W(DT_W)) u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_off  (req_w[i]),
      .dt_en    (dt_en),
      .dt_count (dt_count),
      .gate_o   (gate_o[i])
    );
  end

  assign rd_data = {{PAD_W{1'b0}}, (rd_sel ? stage1_w : stage0_w)};
endmodule

// File: rtl/tpo_seq_chk.sv
module tpo_seq_chk
  import tpo_pkg::*;
#(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             xfer_trig,
  input logic             rd_sel,
  input logic [REG_W-1:0] rd_data,
  input logic             dt_en,
  input gate_vec_t        req,
  input gate_vec_t        gate_o
);
  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (gate_o == ALL_OFF));

  p_read_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_trig |=> (!$stable(rd_sel) || $stable(rd_data)));

  for (genvar k = 0; k < NUM_PHASE; k++) begin : g_pair_chk
    p_pair_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(!gate_o[2*k] && !gate_o[2*k+1]));
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line_chk
    p_release_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req[i] |=> gate_o[i]);
    p_engage_nodt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!dt_en && !req[i]) |=> !gate_o[i]);
    p_engage_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gate_o[i]) |-> $past(!req[i]));
  end
endmodule

bind tpo_seq tpo_seq_chk #(.REG_W(REG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .xfer_trig (xfer_trig),
  .rd_sel    (rd_sel),
  .rd_data   (rd_data),
  .dt_en     (dt_en),
  .req       (req_w),
  .gate_o    (gate_o)
);

// File: tb/tpo_seq_bench.sv
module tpo_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_sel = 1'b0;
  logic [7:0] rd_data;
  logic       xfer_trig = 1'b0;
  logic [2:0] os_pulse = '0;
  logic       dt_en = 1'b0;
  logic [7:0] dt_count = '0;
  logic [5:0] gate_o;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    int         due;
    logic [5:0] val;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t cur;

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  tpo_seq u_tpo_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .rd_sel    (rd_sel),
    .rd_data   (rd_data),
    .xfer_trig (xfer_trig),
    .os_pulse  (os_pulse),
    .dt_en     (dt_en),
    .dt_count  (dt_count),
    .gate_o    (gate_o)
  );

  // Monitor: compares queued expectations in their due cycle.
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
      cur = exp_q.pop_front();
      n_chk++;
      if (cur.due != cyc) begin
        n_fail++;
        $display("FAIL %s: gate check missed, due %0d now %0d", cur.tag, cur.due, cyc);
      end else if (gate_o !== cur.val) begin
        n_fail++;
        $display("FAIL %s: gate_o actual %h expected %h (cycle %0d)", cur.tag, gate_o, cur.val, cyc);
      end
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic expect_gate(input int dly, input logic [5:0] v, input string tag);
    exp_q.push_back('{cyc + dly, v, tag});
  endtask

  task automatic check_rd(input logic sel, input logic [7:0] exp, input string tag);
    rd_sel = sel;
    #1;
    n_chk++;
    if (rd_data !== exp) begin
      n_fail++;
      $display("FAIL %s: rd_data[sel %0d] actual %h expected %h", tag, sel, rd_data, exp);
    end
  endtask

  task automatic check_gate_now(input logic [5:0] v, input string tag);
    n_chk++;
    if (gate_o !== v) begin
      n_fail++;
      $display("FAIL %s: gate_o actual %h expected %h", tag, gate_o, v);
    end
  endtask

  task automatic write_buf(input logic sel, input logic [7:0] d);
    step();
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() > 0) step();
  endtask

  task automatic trigger(input logic [5:0] prev, input logic [5:0] nxt, input string tag);
    step();
    xfer_trig = 1'b1;
    expect_gate(1, prev, tag);
    expect_gate(2, nxt, tag);
    step();
    xfer_trig = 1'b0;
  endtask

  task automatic os_rise(input int ph, input logic [5:0] cur_v);
    step();
    os_pulse[ph] = 1'b1;
    expect_gate(2, cur_v, "R11");
    expect_gate(3, cur_v, "R11");
  endtask

  task automatic os_fall(input int ph, input logic [5:0] prev, input logic [5:0] nxt);
    step();
    os_pulse[ph] = 1'b0;
    expect_gate(1, prev, "R4");
    expect_gate(2, nxt, "R4");
    drain();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual cycle %0d expected below 20000", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    check_gate_now(6'h3F, "R1");
    check_rd(1'b0, 8'h3F, "R1");
    check_rd(1'b1, 8'h3F, "R1");

    // R2: writes alone change nothing visible
    write_buf(1'b0, 8'hF6);
    write_buf(1'b1, 8'hD9);
    step();
    check_gate_now(6'h3F, "R2");
    check_rd(1'b0, 8'h3F, "R2");
    check_rd(1'b1, 8'h3F, "R2");

    // R3/R5: transfer; U-high and V-low active
    trigger(6'h3F, 6'h36, "R3");
    check_rd(1'b0, 8'h36, "R3");
    check_rd(1'b1, 8'h19, "R3");
    drain();

    // R4/R5/R11: per-phase falling edges take stage-1 bits
    os_rise(0, 6'h36);
    drain();
    os_fall(0, 6'h36, 6'h35);
    os_rise(2, 6'h35);
    drain();
    os_fall(2, 6'h35, 6'h15);
    os_rise(1, 6'h15);
    drain();
    os_fall(1, 6'h15, 6'h19);

    // R9: both U lines requested active -> both held off
    write_buf(1'b0, 8'h3C);
    trigger(6'h19, 6'h3F, "R9");
    drain();

    // R10: transfer wins over a same-cycle falling edge
    write_buf(1'b0, 8'h3E);
    write_buf(1'b1, 8'h3D);
    os_rise(0, 6'h3F);
    drain();
    step();
    xfer_trig = 1'b1;
    os_pulse[0] = 1'b0;
    expect_gate(2, 6'h3E, "R10");
    step();
    xfer_trig = 1'b0;
    check_rd(1'b1, 8'h3D, "R10");
    drain();

    // R6/R7: dead time N=5, U releases at once, V engages late
    dt_en = 1'b1;
    dt_count = 8'd5;
    write_buf(1'b0, 8'h3B);
    step();
    xfer_trig = 1'b1;
    expect_gate(1, 6'h3E, "R7");
    expect_gate(2, 6'h3F, "R6");
    expect_gate(7, 6'h3F, "R7");
    expect_gate(8, 6'h3B, "R7");
    step();
    xfer_trig = 1'b0;
    drain();

    // R8: request withdrawn during the countdown
    write_buf(1'b0, 8'h3E);
    trigger(6'h3B, 6'h3F, "R8");
    write_buf(1'b0, 8'h3F);
    step();
    xfer_trig = 1'b1;
    expect_gate(1, 6'h3F, "R8");
    expect_gate(10, 6'h3F, "R8");
    step();
    xfer_trig = 1'b0;
    drain();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule